// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for a four-beat burst into a synchronous cache memory array. A burst begins when either of two start strobes is asserted: one driven by the processor, one by the cache controller. On that clock edge the block captures the presented address. The upper bits of that address stay fixed for the rest of the burst. The two low bits then come from an internal beat counter, which steps only on cycles where the advance input is asserted.

A static order input chooses how the beat number becomes the low address bits:
- **Linear order** adds the beat number to the start offset, modulo four.
- **Interleaved order** XORs the beat number with the start offset.

The counter wraps after the fourth beat and keeps cycling while advances continue. A single chip-select input gates both start strobes. All inputs are sampled on the rising clock edge, and the address is presented from a register.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `addr_out` becomes all zeros after that edge.
- R2: With `chip_sel` high and `proc_start_n` low at a rising edge, `addr_out` equals `addr_in` after that edge.
- R3: With `chip_sel` high and `ctrl_start_n` low at a rising edge, `addr_out` equals `addr_in` after that edge, exactly as for the processor strobe.
- R4: When neither strobe loads and `advance_n` is high, `addr_out` keeps its value.
- R5: With `mode_intlv` low (linear), after n advances since the last load, `addr_out[1:0]` equals (start offset + n) mod 4.
- R6: With `mode_intlv` high (interleaved), after n advances since the last load, `addr_out[1:0]` equals start offset XOR (n mod 4). For example, start offset 2 gives the sequence 2, 3, 0, 1.
- R7: Advances never change `addr_out[ADDR_W-1:2]`; those bits keep the value captured at the last load.
- R8: When a loading strobe and `advance_n` are both low in the same cycle, the load wins and `addr_out` equals `addr_in`.
- R9: A start strobe with `chip_sel` low is ignored. The address holds if `advance_n` is high, and steps if `advance_n` is low.
- R10: After four advances the low bits return to the start offset, and further advances repeat the same sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel | input | 1 | Active-high gate for both start strobes |
| proc_start_n | input | 1 | Processor burst-start strobe, active low |
| ctrl_start_n | input | 1 | Controller burst-start strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| mode_intlv | input | 1 | Order select: 0 = linear, 1 = interleaved |
| addr_in | input | ADDR_W | Start address captured on a load |
| addr_out | output | ADDR_W | Registered word address to the array |

## Verification
The assertions check the local, one-cycle behaviour on every cycle:
- a load captures the input address;
- an idle cycle holds the address;
- the upper bits stay still unless a load occurs;
- a linear step adds one to the low bits;
- an interleaved step always flips bit 0.

A one-step relation cannot confirm the full interleaved sequence, the wrap back to the start offset after four beats, or the priority rules. Those are shown only by the bench sweeping every start offset in both orders across nine advances, with stall cycles inserted, and by its directed cases for strobe-versus-advance and a deselected strobe.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int OFS_W = 2;
    localparam int BEATS = 1 << OFS_W;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_STEP = 2'd1,
        CMD_LOAD = 2'd2
    } burst_cmd_e;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } burst_order_e;

    typedef struct packed {
        logic [OFS_W-1:0] start;
        logic [OFS_W-1:0] beat;
    } burst_pos_t;

    function automatic logic [OFS_W-1:0] beat_offset(
        input logic [OFS_W-1:0] start,
        input logic [OFS_W-1:0] beat,
        input burst_order_e     ord
    );
        logic [OFS_W-1:0] res;
        if (ord == ORD_XOR) res = start ^ beat;
        else                res = start + beat;
        return res;
    endfunction

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
    import burst_seq_pkg::*;
(
    input  logic       chip_sel,
    input  logic       proc_start_n,
    input  logic       ctrl_start_n,
    input  logic       advance_n,
    output burst_cmd_e cmd
);
    logic start_req;

    always_comb begin
        start_req = chip_sel && (!proc_start_n || !ctrl_start_n);
        if (start_req)       cmd = CMD_LOAD;
        else if (!advance_n) cmd = CMD_STEP;
        else                 cmd = CMD_HOLD;
    end
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
    import burst_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  burst_cmd_e       cmd,
    input  burst_order_e     ord,
    input  logic [OFS_W-1:0] load_ofs,
    output logic [OFS_W-1:0] low_q
);
    burst_pos_t       pos_q;
    logic [OFS_W-1:0] next_beat;

    always_comb begin
        next_beat = pos_q.beat + OFS_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            low_q <= '0;
        end else begin
            case (cmd)
                CMD_LOAD: begin
                    pos_q.start <= load_ofs;
                    pos_q.beat  <= '0;
                    low_q       <= load_ofs;
                end
                CMD_STEP: begin
                    pos_q.beat <= next_beat;
                    low_q      <= beat_offset(pos_q.start, next_beat, ord);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_sel,
    input  logic              proc_start_n,
    input  logic              ctrl_start_n,
    input  logic              advance_n,
    input  logic              mode_intlv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int HI_W = ADDR_W - OFS_W;

    burst_cmd_e       cmd;
    burst_order_e     ord;
    logic [HI_W-1:0]  upper_q;
    logic [OFS_W-1:0] low_q;

    assign ord = burst_order_e'(mode_intlv);

    burst_cmd_decode u_dec (
        .chip_sel     (chip_sel),
        .proc_start_n (proc_start_n),
        .ctrl_start_n (ctrl_start_n),
        .advance_n    (advance_n),
        .cmd          (cmd)
    );

    burst_beat_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .ord      (ord),
        .load_ofs (addr_in[OFS_W-1:0]),
        .low_q    (low_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                  upper_q <= '0;
        else if (cmd == CMD_LOAD) upper_q <= addr_in[ADDR_W-1:OFS_W];
    end

    assign addr_out = {upper_q, low_q};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              chip_sel,
    input logic              proc_start_n,
    input logic              ctrl_start_n,
    input logic              advance_n,
    input logic              mode_intlv,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out
);
    logic ld;
    assign ld = chip_sel && (!proc_start_n || !ctrl_start_n);

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        ld |=> addr_out == $past(addr_in)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ld && advance_n) |=> $stable(addr_out)); // R4

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(addr_out[ADDR_W-1:2])); // R7

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!ld && !advance_n && !mode_intlv) |=>
            addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1)); // R5

    AST_XOR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!ld && !advance_n && mode_intlv) |=>
            addr_out[0] != $past(addr_out[0])); // R6
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .chip_sel     (chip_sel),
    .proc_start_n (proc_start_n),
    .ctrl_start_n (ctrl_start_n),
    .advance_n    (advance_n),
    .mode_intlv   (mode_intlv),
    .addr_in      (addr_in),
    .addr_out     (addr_out)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          chip_sel = 1'b1;
    logic          proc_start_n = 1'b1;
    logic          ctrl_start_n = 1'b1;
    logic          advance_n = 1'b1;
    logic          mode_intlv = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
        .clk          (clk),
        .rst          (rst),
        .chip_sel     (chip_sel),
        .proc_start_n (proc_start_n),
        .ctrl_start_n (ctrl_start_n),
        .advance_n    (advance_n),
        .mode_intlv   (mode_intlv),
        .addr_in      (addr_in),
        .addr_out     (addr_out)
    );

    task automatic cycle(input logic cs, input logic p_n, input logic c_n,
                         input logic a_n, input logic [AW-1:0] a);
        @(negedge clk);
        chip_sel = cs; proc_start_n = p_n; ctrl_start_n = c_n;
        advance_n = a_n; addr_in = a;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [AW-1:0] exp);
        total++;
        if (addr_out !== exp) begin
            bad++;
            $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
        end
    endtask

    function automatic logic [1:0] expect_low(input logic m, input logic [1:0] s,
                                              input int n);
        logic [1:0] nb;
        nb = 2'(n % 4);
        return m ? (s ^ nb) : 2'(s + nb);
    endfunction

    initial begin
        logic [AW-1:0] a0;
        cycle(1, 1, 1, 1, '0);
        cycle(1, 1, 1, 1, '0);
        check("R1", '0);
        rst = 1'b0;

        for (int m = 0; m < 2; m++) begin
            for (int off = 0; off < 4; off++) begin
                @(negedge clk);
                mode_intlv = m[0];
                a0 = {16'(16'h1357 + m * 16'h0404 + off * 16'h0111), 2'(off)};
                if (off % 2 == 0) begin
                    cycle(1, 0, 1, 1, a0);
                    check("R2", a0);
                end else begin
                    cycle(1, 1, 0, 1, a0);
                    check("R3", a0);
                end
                for (int n = 1; n <= 9; n++) begin
                    cycle(1, 1, 1, 0, ~a0);
                    if (n == 4 || n == 8)
                        check("R10", {a0[AW-1:2], 2'(off)});
                    else if (m == 0)
                        check("R5", {a0[AW-1:2], expect_low(0, 2'(off), n)});
                    else
                        check("R6", {a0[AW-1:2], expect_low(1, 2'(off), n)});
                    if (n == 2) begin
                        cycle(1, 1, 1, 1, ~a0);
                        check("R4", {a0[AW-1:2], expect_low(m[0], 2'(off), n)});
                    end
                end
                check("R7", {a0[AW-1:2], expect_low(m[0], 2'(off), 9)});
            end
        end

        // R8: load wins over a simultaneous advance
        mode_intlv = 1'b0;
        cycle(1, 0, 1, 1, 18'h2A5C1);
        cycle(1, 1, 1, 0, '0);
        check("R5", 18'h2A5C2);
        cycle(1, 1, 0, 0, 18'h1F0F3);
        check("R8", 18'h1F0F3);
        cycle(1, 0, 0, 0, 18'h03332);
        check("R8", 18'h03332);

        // R9: deselected strobe is ignored
        cycle(0, 0, 1, 1, 18'h3FFFC);
        check("R9", 18'h03332);
        cycle(0, 1, 0, 0, 18'h3FFFC);
        check("R9", 18'h03333);

        // R1: reset mid-burst
        @(negedge clk); rst = 1'b1;
        cycle(1, 1, 1, 0, '0);
        check("R1", '0);
        rst = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule